// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two level signals of an incremental encoder, A and B, into a position value. Software picks one of four counting sources: full x4 quadrature, pulse with a direction input, up-only or down-only. The counter runs from zero to a ceiling that software programs, and it wraps at either end. An enable bit gates all counting, while the input history keeps being tracked so that turning counting on never produces a spurious step.

A and B arrive already synchronous to `clk_i`. A step is seen in the clock cycle where an input level differs from the level sampled on the previous edge. The step shows on `pos_o` right after that edge. The register port is a single-cycle write strobe with a combinational read path. Any access to the 16-bit control registers uses bits 15:0 of the data bus, so `CNT_W` must be at least 16.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, the position is 0, the ceiling holds `RST_MAX` (all ones by default), the source field, the edge-select bit, the enable bit and the error flag are all 0.
- R2: While the enable bit (bit 3 of the main control register at byte offset 0x2A) is 0, input activity leaves the position unchanged.
- R3: With source field 0 (quadrature), each single-bit change of {A,B} along 00→10→11→01→00 adds one. Each change along the reverse order subtracts one. The new value is on `pos_o` after the clock edge that samples the change.
- R4: Counting up from a position equal to or above the ceiling gives 0. Counting down from 0 gives the ceiling.
- R5: A write to the position register (offset 0x00) takes effect only when the value is not above the ceiling. Otherwise the position is left unchanged. Writes to the ceiling (offset 0x08) always take effect.
- R6: An accepted position write in the same cycle as a count step loads the written value, and the step is dropped.
- R7: With source field 1 (pulse/direction), only rising edges of A count. B at 1 counts up and B at 0 counts down. Changes on B alone, and falling edges of A, do not count.
- R8: With source field 2 (up-only), B is ignored. Edge-select bit 11 of the decoder control register set to 0 counts only rising edges of A. Set to 1, it counts both edges of A.
- R9: With source field 3 (down-only), the rules of R8 apply, but each counted edge of A subtracts one.
- R10: In quadrature mode with counting enabled, a change of both A and B in one cycle does not count and sets the error flag `err_o`. The flag then stays set until reset.
- R11: Register reads return the position at 0x00 and the ceiling at 0x08. The decoder control register at 0x28 returns the source field in bits 15:14 and the edge-select bit in bit 11. The main control register at 0x2A returns the enable bit in bit 3. All other bits, and all other offsets, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder input A (or count pulse) |
| enc_b_i | input | 1 | Encoder input B (or direction) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data, combinational on address |
| pos_o | output | CNT_W | Current position |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The bench builds the block with `CNT_W` = 16 and the default all-ones reset ceiling. This makes the control registers exactly fill the data bus, and it makes the reset-state down-wrap to 0xFFFF easy to see. The bench programs a small ceiling of 9, so both wrap directions are reached within a few encoder steps. One walk of the inputs carries the A/B state across mode changes. Because of this, the edge seen first after each mode switch depends on the history from the previous mode, and that edge is checked explicitly.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  localparam logic [7:0] OFS_POS  = 8'h00;
  localparam logic [7:0] OFS_MAX  = 8'h08;
  localparam logic [7:0] OFS_DEC  = 8'h28;
  localparam logic [7:0] OFS_CTL  = 8'h2A;

  localparam int unsigned SRC_LSB = 14;
  localparam int unsigned XCR_BIT = 11;
  localparam int unsigned EN_BIT  = 3;
endpackage

// File: rtl/qenc_in_track.sv
module qenc_in_track #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] lvl_i,
  output logic [N_IN-1:0] prev_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_trk
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= lvl_i[i];
    end
    assign prev_o[i] = q;
  end
endmodule

// File: rtl/qenc_step_dec.sv
module qenc_step_dec
  import qenc_pkg::*;
(
  input  logic [1:0] prev_i,   // {A,B} last cycle
  input  logic [1:0] cur_i,    // {A,B} now
  input  src_e       src_i,
  input  logic       both_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       bad_o
);
  logic a_chg, b_chg, a_rise, a_hit;

  always_comb begin
    a_chg  = prev_i[1] ^ cur_i[1];
    b_chg  = prev_i[0] ^ cur_i[0];
    a_rise = cur_i[1] & ~prev_i[1];
    a_hit  = both_i ? a_chg : a_rise;
    up_o   = 1'b0;
    dn_o   = 1'b0;
    bad_o  = 1'b0;
    unique case (src_i)
      SRC_QUAD: begin
        if (a_chg && b_chg) begin
          bad_o = 1'b1;
        end else if (a_chg || b_chg) begin
          // forward Gray order: A leads B
          up_o = (prev_i[1] == cur_i[0]);
          dn_o = (prev_i[1] != cur_i[0]);
        end
      end
      SRC_DIR: begin
        up_o = a_rise & cur_i[0];
        dn_o = a_rise & ~cur_i[0];
      end
      SRC_UP:   up_o = a_hit;
      SRC_DOWN: dn_o = a_hit;
      default: ;
    endcase
  end
endmodule

// File: rtl/qenc_pos_cnt.sv
module qenc_pos_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] pos_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (wdata_i <= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (wr_ok) begin
      pos_q <= wdata_i;
    end else if (en_i && up_i) begin
      pos_q <= (pos_q >= max_i) ? '0 : pos_q + 1'b1;
    end else if (en_i && dn_i) begin
      pos_q <= (pos_q == '0) ? max_i : pos_q - 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int unsigned    ADDR_W  = 8,
  parameter int unsigned    CNT_W   = 32,
  parameter logic [CNT_W-1:0] RST_MAX = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic              err_o
);
  logic [1:0]       cur_ab, prev_ab;
  logic [CNT_W-1:0] max_q, pos;
  src_e             src_q;
  logic             xcr_q, en_q, err_q;
  logic             step_up, step_dn, step_bad;
  logic             sel_pos, sel_max, sel_dec, sel_ctl;
  logic             wr_pos;

  assign cur_ab  = {enc_a_i, enc_b_i};
  assign sel_pos = (reg_addr_i == ADDR_W'(OFS_POS));
  assign sel_max = (reg_addr_i == ADDR_W'(OFS_MAX));
  assign sel_dec = (reg_addr_i == ADDR_W'(OFS_DEC));
  assign sel_ctl = (reg_addr_i == ADDR_W'(OFS_CTL));
  assign wr_pos  = reg_we_i && sel_pos;

  qenc_in_track #(.N_IN(2)) u_trk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cur_ab),
    .prev_o(prev_ab)
  );

  qenc_step_dec u_dec (
    .prev_i(prev_ab),
    .cur_i (cur_ab),
    .src_i (src_q),
    .both_i(xcr_q),
    .up_o  (step_up),
    .dn_o  (step_dn),
    .bad_o (step_bad)
  );

  qenc_pos_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .wr_i   (wr_pos),
    .wdata_i(reg_wdata_i),
    .max_i  (max_q),
    .pos_o  (pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= RST_MAX;
      src_q <= SRC_QUAD;
      xcr_q <= 1'b0;
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (reg_we_i && sel_max) max_q <= reg_wdata_i;
      if (reg_we_i && sel_dec) begin
        src_q <= src_e'(reg_wdata_i[SRC_LSB+1:SRC_LSB]);
        xcr_q <= reg_wdata_i[XCR_BIT];
      end
      if (reg_we_i && sel_ctl) en_q <= reg_wdata_i[EN_BIT];
      if (en_q && step_bad)    err_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_pos) begin
      reg_rdata_o = pos;
    end else if (sel_max) begin
      reg_rdata_o = max_q;
    end else if (sel_dec) begin
      reg_rdata_o[SRC_LSB+1:SRC_LSB] = src_q;
      reg_rdata_o[XCR_BIT]           = xcr_q;
    end else if (sel_ctl) begin
      reg_rdata_o[EN_BIT] = en_q;
    end
  end

  assign pos_o = pos;
  assign err_o = err_q;
endmodule

// File: rtl/qenc_pos_counter_chk.sv
module qenc_pos_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             up_i,
  input logic             dn_i,
  input logic             bad_i,
  input logic             wr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] max_i,
  input logic [CNT_W-1:0] pos_i,
  input logic             err_i
);
  logic wr_ok;
  assign wr_ok = wr_i && (wdata_i <= max_i);

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_ok) |=> $stable(pos_i));

  // R3
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_i && dn_i));

  // R4
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !wr_ok && pos_i >= max_i) |=> (pos_i == '0));

  // R4
  wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dn_i && !wr_ok && pos_i == '0) |=> (pos_i == $past(max_i)));

  // R6
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (pos_i == $past(wdata_i)));

  // R10
  bad_nocount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bad_i && !wr_ok) |=> ($stable(pos_i) && err_i));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);
endmodule

bind qenc_pos_counter qenc_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_q),
  .up_i   (step_up),
  .dn_i   (step_dn),
  .bad_i  (step_bad),
  .wr_i   (wr_pos),
  .wdata_i(reg_wdata_i),
  .max_i  (max_q),
  .pos_i  (pos_o),
  .err_i  (err_o)
);

// File: tb/sim_qenc_pos_counter.sv
module sim_qenc_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b0, b = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, pos;
  logic          err;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_pos_counter #(.ADDR_W(AW), .CNT_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pos_o(pos), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = ad; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] ad, output logic [DW-1:0] d);
    @(negedge clk); addr = ad; #1; d = rdata;
  endtask

  task automatic mv(input logic na, input logic nb);
    @(negedge clk); a = na; b = nb;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 pos", pos, 0);
    chk("R1 err", err, 0);
    rd(8'h08, d); chk("R1 max", d, 16'hFFFF);
    rd(8'h28, d); chk("R1 dec ctl", d, 0);
    rd(8'h2A, d); chk("R1 main ctl", d, 0);
  endtask

  task automatic t_gate;
    mv(1, 0); mv(1, 1);
    chk("R2 disabled", pos, 0);
  endtask

  task automatic t_quad;
    wr(8'h2A, 16'h0008);
    mv(0, 1); mv(0, 0); mv(1, 0); mv(1, 1);
    chk("R3 forward x4", pos, 4);
    mv(1, 0); mv(0, 0);
    chk("R3 reverse", pos, 2);
  endtask

  task automatic t_wrap;
    wr(8'h08, 16'd9);
    wr(8'h00, 16'd0);
    mv(0, 1);
    chk("R4 down wrap", pos, 9);
    mv(0, 0);
    chk("R4 up wrap", pos, 0);
  endtask

  task automatic t_write;
    logic [DW-1:0] d;
    wr(8'h00, 16'd20);
    chk("R5 reject over max", pos, 0);
    wr(8'h00, 16'd9);
    chk("R5 accept at max", pos, 9);
    rd(8'h08, d); chk("R5 max write", d, 9);
    wr(8'h00, 16'd7);
  endtask

  task automatic t_prio;
    @(negedge clk); we = 1'b1; addr = 8'h00; wdata = 16'd3; a = 1'b1; b = 1'b0;
    @(negedge clk); we = 1'b0;
    chk("R6 write beats step", pos, 3);
    mv(1, 1);
    chk("R6 next step", pos, 4);
  endtask

  task automatic t_illegal;
    chk("R10 err clear", err, 0);
    mv(0, 0);
    chk("R10 no count", pos, 4);
    chk("R10 err set", err, 1);
    mv(1, 0);
    chk("R10 count resumes", pos, 5);
    chk("R10 err sticky", err, 1);
  endtask

  task automatic t_dir;
    wr(8'h28, 16'h4000);
    mv(0, 1); chk("R7 fall ignored", pos, 5);
    mv(1, 1); chk("R7 rise B=1 up", pos, 6);
    mv(0, 1); mv(0, 0); chk("R7 B alone ignored", pos, 6);
    mv(1, 0); chk("R7 rise B=0 down", pos, 5);
  endtask

  task automatic t_up;
    logic [DW-1:0] d;
    wr(8'h28, 16'h8000);
    mv(0, 0); chk("R8 fall ignored", pos, 5);
    mv(1, 0); chk("R8 rise counts", pos, 6);
    mv(1, 1); mv(0, 1); chk("R8 B and fall ignored", pos, 6);
    wr(8'h28, 16'h8800);
    mv(1, 1); mv(0, 1); chk("R8 both edges", pos, 8);
    rd(8'h28, d); chk("R11 dec ctl readback", d, 16'h8800);
  endtask

  task automatic t_down;
    wr(8'h28, 16'hC000);
    mv(1, 1); chk("R9 rise down", pos, 7);
    mv(0, 1); chk("R9 fall ignored", pos, 7);
    wr(8'h28, 16'hC800);
    mv(1, 1); mv(0, 0); chk("R9 both edges", pos, 5);
    wr(8'h00, 16'd0);
    mv(1, 0); chk("R9 wrap to max", pos, 9);
  endtask

  task automatic t_regs;
    logic [DW-1:0] d;
    wr(8'h2A, 16'hFFFF);
    rd(8'h2A, d); chk("R11 main ctl mask", d, 16'h0008);
    rd(8'h04, d); chk("R11 unmapped", d, 0);
    rd(8'h00, d); chk("R11 pos readback", d, 9);
    wr(8'h2A, 16'h0000);
    mv(0, 0); mv(1, 0); chk("R2 disable holds", pos, 9);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_quad;
    t_wrap;
    t_write;
    t_prio;
    t_illegal;
    t_dir;
    t_up;
    t_down;
    t_regs;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule